// File: doc/BRIEF.md
# Temporal Dither Subframe Sequencer

This block lets an LED driver show intensity steps finer than the strip's integer codes. Each colour channel arrives as an integer level plus a fraction code counted in sevenths. The block repeats every base frame as seven fast subframes. In a chosen subset of those subframes it raises the channel's output by one code. The eye averages the subframes, so the channel appears to sit between the two integer steps, in proportion to the fraction.

A subframe counter advances on each strip-refresh strobe, and all channels share it. When the counter wraps from the last subframe back to the first, the block latches fresh levels and fractions and raises a one-cycle new-frame flag. When brightness is scaled down upstream, the low bits lost to the scaling should be turned into the fraction code. The dither then recovers part of the resolution that the scaling removed.

Top module: `dith_top`

## Requirements
- R1: After reset the subframe index is 0, `frame_start` is 0 and every channel of `px_out` is 0. These values hold until the first latched frame.
- R2: Each clock cycle with `refresh` high advances the subframe index by one. The index runs through 0 to 6 and holds in cycles without `refresh`.
- R3: A `refresh` seen in subframe 6 wraps the index to 0. `frame_start` is high in the following cycle, and only for that one cycle.
- R4: `lvl_in` and `frac_in` are latched only by the wrapping strobe. Changes to them at any other time have no effect on `px_out`.
- R5: Each channel outputs its latched level plus one add bit. The add bit is taken from a table indexed by fraction code and subframe. Listed over subframes 0 to 6, the table rows are: code 0 `0000000`, code 1 `0001000`, code 2 `0010010`, code 3 `0101010`, code 4 `0101101`, code 5 `1101110`, code 6 `0111111`.
- R6: When the latched level is the maximum code, the output stays at the maximum and never wraps to 0.
- R7: Fraction code 7, which lies outside the defined range, uses the row for code 6.
- R8: Channel c occupies bits `[c*LVL_W +: LVL_W]` of `lvl_in` and `px_out`, and bits `[c*3 +: 3]` of `frac_in`. The channels share one subframe index, and each applies its own fraction code.
- R9: Over one full base frame, a channel below the maximum is raised in exactly as many subframes as its fraction code (7 counts as 6).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| refresh | input | 1 | Strip-refresh strobe, one subframe step per high cycle |
| lvl_in | input | NCH*LVL_W | Integer level per channel |
| frac_in | input | NCH*3 | Fraction code per channel, in sevenths |
| px_out | output | NCH*LVL_W | Dithered level per channel for the current subframe |
| frame_start | output | 1 | One-cycle pulse after the subframe index wraps to 0 |

## Verification
A wrong subframe index shows at once at `px_out`. The add bit comes from the wrong table column in the very cycle after the strobe, and `frame_start` appears at the wrong point in the strobe sequence. A latch that loads on the wrong strobe shows as an output that follows mid-frame input changes, within one strobe. A bad table entry or a missing saturation may pass a single subframe unnoticed. It does show as a wrong raised-subframe count at the end of the base frame, or as a 0 on a full-scale channel.

// File: rtl/dith_pkg.sv
package dith_pkg;
  localparam int NSUB   = 7;
  localparam int SUB_W  = $clog2(NSUB);
  localparam int FRAC_W = 3;

  // bit s of the row = add bit in subframe s
  function automatic logic [NSUB-1:0] pat_row(input logic [FRAC_W-1:0] f);
    logic [NSUB-1:0] r;
    case (f)
      3'd0:    r = 7'b0000000;
      3'd1:    r = 7'b0001000;
      3'd2:    r = 7'b0100100;
      3'd3:    r = 7'b0101010;
      3'd4:    r = 7'b1011010;
      3'd5:    r = 7'b0111011;
      default: r = 7'b1111110;   // codes 6 and 7
    endcase
    return r;
  endfunction

  function automatic logic pat_bit(input logic [FRAC_W-1:0] f,
                                   input logic [SUB_W-1:0]  s);
    logic [NSUB-1:0] r;
    r = pat_row(f);
    return r[s];
  endfunction
endpackage

// File: rtl/dith_seq.sv
module dith_seq
  import dith_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             refresh,
  output logic [SUB_W-1:0] sub,
  output logic             wrap,
  output logic             frame_start
);
  localparam logic [SUB_W-1:0] LAST = SUB_W'(NSUB - 1);

  logic at_last;
  assign at_last = (sub == LAST);
  assign wrap    = refresh && at_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sub         <= '0;
      frame_start <= 1'b0;
    end else begin
      frame_start <= wrap;
      if (wrap)         sub <= '0;
      else if (refresh) sub <= sub + SUB_W'(1);
    end
  end

  a_r2_range: assert property (@(posedge clk) disable iff (!rst_n)
    sub <= LAST);
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh && !at_last) |=> (sub == $past(sub) + SUB_W'(1)));
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !refresh |=> $stable(sub));
  a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh && at_last) |=> (sub == '0 && frame_start));
  a_r3_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);
endmodule

// File: rtl/dith_lane.sv
module dith_lane
  import dith_pkg::*;
#(
  parameter int LVL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrap,
  input  logic [SUB_W-1:0]  sub,
  input  logic [LVL_W-1:0]  lvl_in,
  input  logic [FRAC_W-1:0] frac_in,
  output logic [LVL_W-1:0]  px_out
);
  localparam logic [LVL_W-1:0] TOP = {LVL_W{1'b1}};

  function automatic logic [LVL_W-1:0] sat_add(input logic [LVL_W-1:0] a,
                                               input logic b);
    if (b && a != TOP) return a + LVL_W'(1);
    return a;
  endfunction

  logic [LVL_W-1:0]  lvl_q;
  logic [FRAC_W-1:0] frac_q;
  logic              bump;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q  <= '0;
      frac_q <= '0;
    end else if (wrap) begin
      lvl_q  <= lvl_in;
      frac_q <= frac_in;
    end
  end

  assign bump   = pat_bit(frac_q, sub);
  assign px_out = sat_add(lvl_q, bump);

  a_r4_latch_only_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> ($stable(lvl_q) && $stable(frac_q)));
  a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    px_out >= lvl_q);
  a_r5_step_max_one: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, px_out} - {1'b0, lvl_q}) <= (LVL_W+1)'(1));
  a_r7_zero_code_flat: assert property (@(posedge clk) disable iff (!rst_n)
    (frac_q == '0) |-> (px_out == lvl_q));
endmodule

// File: rtl/dith_top.sv
module dith_top
  import dith_pkg::*;
#(
  parameter int NCH   = 3,
  parameter int LVL_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  refresh,
  input  logic [NCH*LVL_W-1:0]  lvl_in,
  input  logic [NCH*FRAC_W-1:0] frac_in,
  output logic [NCH*LVL_W-1:0]  px_out,
  output logic                  frame_start
);
  logic [SUB_W-1:0] sub;
  logic             wrap;

  dith_seq u_seq (
    .clk(clk), .rst_n(rst_n), .refresh(refresh),
    .sub(sub), .wrap(wrap), .frame_start(frame_start)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    dith_lane #(.LVL_W(LVL_W)) u_lane (
      .clk(clk), .rst_n(rst_n), .wrap(wrap), .sub(sub),
      .lvl_in (lvl_in [c*LVL_W  +: LVL_W]),
      .frac_in(frac_in[c*FRAC_W +: FRAC_W]),
      .px_out (px_out [c*LVL_W  +: LVL_W])
    );
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (sub == '0 && !frame_start));
endmodule

// File: tb/sim_dith_top.sv
`timescale 1ns/1ps
module sim_dith_top;
  localparam int NCH = 3;
  localparam int LW  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic refresh = 1'b0;
  logic [NCH*LW-1:0] lvl_in = '0;
  logic [NCH*3-1:0]  frac_in = '0;
  logic [NCH*LW-1:0] px_out;
  logic              frame_start;

  always #4 clk = ~clk;

  dith_top #(.NCH(NCH), .LVL_W(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .refresh(refresh), .lvl_in(lvl_in),
    .frac_in(frac_in), .px_out(px_out), .frame_start(frame_start)
  );

  // table written left to right as subframe 0..6
  bit [0:6] rows [7] = '{7'b0000000, 7'b0001000, 7'b0010010, 7'b0101010,
                         7'b0101101, 7'b1101110, 7'b0111111};

  int total = 0, bad = 0;
  int sub_m = 0;
  int lvl_m [NCH];
  int frac_m [NCH];
  int raised [NCH];
  bit frame_full = 0;
  bit done = 0;

  function automatic int expect_px(int lvl, int fr, int s);
    int f = (fr > 6) ? 6 : fr;
    if (lvl == 255) return 255;
    return lvl + rows[f][s];
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_px(string tag);
    for (int c = 0; c < NCH; c++)
      check(tag, int'(px_out[c*LW +: LW]), expect_px(lvl_m[c], frac_m[c], sub_m));
  endtask

  task automatic set_ch(int c, int lvl, int fr);
    lvl_in[c*LW +: LW] = LW'(lvl);
    frac_in[c*3 +: 3]  = 3'(fr);
  endtask

  task automatic randomize_inputs();
    for (int c = 0; c < NCH; c++)
      set_ch(c, ($urandom % 8 == 0) ? 255 : $urandom % 256, $urandom % 8);
  endtask

  // one strobe, then idle gap; frame index picks directed values before wrap
  task automatic strobe(int frame_idx);
    bit wrapping = (sub_m == 6);
    randomize_inputs();
    if (wrapping) begin
      case (frame_idx)
        0: begin set_ch(0, 16, 1); set_ch(1, 0, 3); set_ch(2, 100, 6); end
        1: begin set_ch(0, 255, 6); set_ch(1, 254, 6); set_ch(2, 255, 0); end
        2: begin set_ch(0, 10, 7); set_ch(1, 20, 2); set_ch(2, 30, 5); end
        3: begin set_ch(0, 40, 4); set_ch(1, 7, 0); set_ch(2, 0, 7); end
        default: ;
      endcase
    end
    refresh = 1'b1;
    @(negedge clk);
    refresh = 1'b0;
    if (wrapping) begin
      if (frame_full)
        for (int c = 0; c < NCH; c++)
          if (lvl_m[c] != 255)
            check("R9 raised count", raised[c], (frac_m[c] > 6) ? 6 : frac_m[c]);
      for (int c = 0; c < NCH; c++) begin
        lvl_m[c]  = int'(lvl_in[c*LW +: LW]);
        frac_m[c] = int'(frac_in[c*3 +: 3]);
        raised[c] = 0;
      end
      frame_full = 1;
      sub_m = 0;
      check("R3 frame_start after wrap", int'(frame_start), 1);
    end else begin
      sub_m++;
      check("R2 no frame_start mid frame", int'(frame_start), 0);
    end
    // inputs now change mid-frame and must not reach px_out (R4)
    randomize_inputs();
    check_px(frame_idx == 1 ? "R6 saturate" :
             frame_idx == 2 ? "R7 code seven" : "R5 R8 R4 dither output");
    for (int c = 0; c < NCH; c++)
      raised[c] += int'(px_out[c*LW +: LW]) - lvl_m[c];
    for (int g = $urandom % 3; g > 0; g--) begin
      @(negedge clk);
      check("R3 pulse one cycle", int'(frame_start), 0);
      check_px("R2 R4 hold without strobe");
    end
  endtask

  initial begin
    void'($urandom(1234));
    for (int c = 0; c < NCH; c++) begin lvl_m[c] = 0; frac_m[c] = 0; raised[c] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    randomize_inputs();
    @(negedge clk);
    check("R1 reset frame_start", int'(frame_start), 0);
    for (int c = 0; c < NCH; c++)
      check("R1 reset px_out", int'(px_out[c*LW +: LW]), 0);
    // first partial frame after reset: outputs stay 0 (R1)
    for (int k = 0; k < 6; k++) strobe(-1);
    for (int f = 0; f < 300; f++)
      for (int k = 0; k < 7; k++) strobe(f);
    // one more wrap so the last frame's R9 count is checked
    strobe(-1);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule